// File: doc/BRIEF.md
# UART Receiver Standby and Wakeup Control

This block sits beside a UART receive path and decides whether each completed character is reported to software. Software can park the receiver in a standby state by pulsing a request. While the receiver is parked, finished characters are dropped silently: neither the data-ready flag nor the error flags may be raised. Hardware then watches the line for the wakeup condition that software selected, and clears the standby state on its own when that condition appears.

Two wakeup methods are supported. In idle-line mode, a full character time of continuous logic 1 on the line ends standby, and the next character is delivered. In address-mark mode, a character whose most significant data bit is 1 ends standby, and that character is itself delivered.

The block also produces the enable for the external receive pin. The pin is released whenever the receiver is off, and also when loop mode routes the transmitter back internally. The character interface is a one-cycle strobe from the bit sampler. The sampler cannot be stalled, so this interface has no ready signal and no back-pressure. An accepted character is reported in the same cycle as its strobe.

Top module: `uart_rx_wakeup`

## Requirements
- R1: After reset, `standby` is 0 and `char_accept` is 0. With `rx_en` low, `pin_rx_en` is also 0.
- R2: A `stby_req` pulse while `rx_en` is 1 sets `standby` from the next cycle. A pulse while `rx_en` is 0 is ignored.
- R3: While `standby` is 1, a `char_done` strobe that is not an address-mark wakeup gives `char_accept` = 0. In idle-line mode (`wake_sel` = 0) this holds for every character, including one whose top bit is 1.
- R4: In address-mark mode (`wake_sel` = 1) and 8-bit framing (`nine_bit` = 0), a character with `char_data[7]` = 1 received during standby is accepted in the same cycle, and `standby` is 0 from the next cycle.
- R5: In 9-bit framing (`nine_bit` = 1), the mark bit is `char_data[8]`. A character with bit 7 set and bit 8 clear does not end standby.
- R6: In idle-line mode, standby ends after the frame length of consecutive `bit_tick` strobes with `line_high` = 1, counted from standby entry. The frame length is 10 ticks in 8-bit framing and 11 ticks in 9-bit framing. One tick fewer leaves standby set.
- R7: A `bit_tick` with `line_high` = 0 during standby restarts the idle count from zero.
- R8: After an idle-line wakeup, the next character is accepted.
- R9: Outside standby, `char_accept` equals `char_done` while `rx_en` is 1. When `rx_en` is 0, `char_accept` is 0.
- R10: `pin_rx_en` is 1 only when `rx_en` is 1 and `loop_mode` is 0.
- R11: Dropping `rx_en` to 0 clears `standby` at the next clock edge. `standby` stays cleared when the receiver is enabled again.
- R12: A `stby_req` pulse in the same cycle as a wakeup condition leaves `standby` at 1. An address-mark character in that cycle is still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receiver enable |
| loop_mode | input | 1 | Internal loopback active; releases the pin |
| stby_req | input | 1 | Software request pulse to enter standby |
| wake_sel | input | 1 | Wakeup method: 0 idle line, 1 address mark |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| bit_tick | input | 1 | One pulse per received bit time |
| line_high | input | 1 | Sampled line level for the current bit time |
| char_done | input | 1 | Character-complete strobe |
| char_data | input | DATA_W+1 | Received data bits; the top bit is used only in 9-bit framing |
| standby | output | 1 | Receiver is in standby |
| char_accept | output | 1 | Qualified character strobe; gates the data-ready and error flags |
| pin_rx_en | output | 1 | Enable for the external receive pin |

## Verification
The hardest case to reach is the exact boundary of the idle-line window. The bench must deliver one tick fewer than a full frame and see that standby still holds, then deliver the final tick and see it clear. It must also break the run with one low bit part-way through. Directed tasks issue ticks one at a time from the cycle after standby entry. They do this for both frame lengths, and they check `standby` after each edge of interest. A separate task puts a standby request and an address-mark character in the same cycle, to exercise the request-over-wakeup priority.

// File: rtl/uart_wake_pkg.sv
package uart_wake_pkg;
  typedef enum logic {
    WAKE_IDLE = 1'b0,
    WAKE_MARK = 1'b1
  } wake_mode_e;
endpackage

// File: rtl/wake_idle_timer.sv
module wake_idle_timer #(
  parameter int DATA_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic bit_tick,
  input  logic line_high,
  input  logic nine_bit,
  output logic idle_hit
);
  // start + data + optional ninth bit + stop
  localparam int FRAME_MAX = DATA_W + 3;
  localparam int CNT_W     = $clog2(FRAME_MAX + 1);

  logic [CNT_W-1:0] ones_cnt;
  logic [CNT_W-1:0] frame_len;

  assign frame_len = nine_bit ? CNT_W'(FRAME_MAX) : CNT_W'(FRAME_MAX - 1);
  assign idle_hit  = arm && bit_tick && line_high &&
                     (ones_cnt == frame_len - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     ones_cnt <= '0;
    else if (!arm)                  ones_cnt <= '0;
    else if (bit_tick) begin
      if (!line_high || idle_hit)   ones_cnt <= '0;
      else                          ones_cnt <= ones_cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/wake_mark_detect.sv
module wake_mark_detect #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W:0] char_data,
  input  logic            nine_bit,
  output logic            mark_bit
);
  assign mark_bit = nine_bit ? char_data[DATA_W] : char_data[DATA_W-1];
endmodule

// File: rtl/wake_standby_reg.sv
module wake_standby_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_en,
  input  logic set_req,
  input  logic wake,
  output logic standby_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       standby_q <= 1'b0;
    else if (!rx_en)  standby_q <= 1'b0;
    else if (set_req) standby_q <= 1'b1;
    else if (wake)    standby_q <= 1'b0;
  end
endmodule

// File: rtl/uart_rx_wakeup.sv
module uart_rx_wakeup
  import uart_wake_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_en,
  input  logic            loop_mode,
  input  logic            stby_req,
  input  logic            wake_sel,
  input  logic            nine_bit,
  input  logic            bit_tick,
  input  logic            line_high,
  input  logic            char_done,
  input  logic [DATA_W:0] char_data,
  output logic            standby,
  output logic            char_accept,
  output logic            pin_rx_en
);
  wake_mode_e mode;
  logic       mark_bit;
  logic       mark_hit;
  logic       idle_hit;
  logic       idle_arm;

  assign mode     = wake_mode_e'(wake_sel);
  assign idle_arm = standby && rx_en && (mode == WAKE_IDLE);
  assign mark_hit = standby && rx_en && (mode == WAKE_MARK) && char_done && mark_bit;

  wake_mark_detect #(.DATA_W(DATA_W)) u_mark (
    .char_data (char_data),
    .nine_bit  (nine_bit),
    .mark_bit  (mark_bit)
  );

  wake_idle_timer #(.DATA_W(DATA_W)) u_idle (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (idle_arm),
    .bit_tick  (bit_tick),
    .line_high (line_high),
    .nine_bit  (nine_bit),
    .idle_hit  (idle_hit)
  );

  wake_standby_reg u_stby (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (rx_en),
    .set_req   (stby_req),
    .wake      (mark_hit || idle_hit),
    .standby_q (standby)
  );

  assign char_accept = rx_en && char_done && (!standby || mark_hit);
  assign pin_rx_en   = rx_en && !loop_mode;
endmodule

// File: rtl/uart_rx_wakeup_chk.sv
module uart_rx_wakeup_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_en,
  input logic stby_req,
  input logic wake_sel,
  input logic char_done,
  input logic standby,
  input logic char_accept
);
  // R2
  stby_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && stby_req) |=> standby);

  // R9
  accept_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    char_accept |-> (char_done && rx_en));

  // R3
  idle_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && !wake_sel) |-> !char_accept);

  // R11
  off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !standby);

  // R4
  mark_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && rx_en && !stby_req && char_accept) |=> !standby);
endmodule

bind uart_rx_wakeup uart_rx_wakeup_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_en       (rx_en),
  .stby_req    (stby_req),
  .wake_sel    (wake_sel),
  .char_done   (char_done),
  .standby     (standby),
  .char_accept (char_accept)
);

// File: tb/uart_rx_wakeup_test.sv
module uart_rx_wakeup_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0, loop_mode = 1'b0, stby_req = 1'b0, wake_sel = 1'b0;
  logic       nine_bit = 1'b0, bit_tick = 1'b0, line_high = 1'b1, char_done = 1'b0;
  logic [8:0] char_data = '0;
  logic       standby, char_accept, pin_rx_en;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  uart_rx_wakeup #(.DATA_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .loop_mode(loop_mode),
    .stby_req(stby_req), .wake_sel(wake_sel), .nine_bit(nine_bit),
    .bit_tick(bit_tick), .line_high(line_high), .char_done(char_done),
    .char_data(char_data), .standby(standby), .char_accept(char_accept),
    .pin_rx_en(pin_rx_en)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic req_standby();
    @(negedge clk); stby_req = 1'b1;
    @(posedge clk); #1 stby_req = 1'b0;
  endtask

  task automatic send_tick(input logic hi);
    @(negedge clk); bit_tick = 1'b1; line_high = hi;
    @(posedge clk); #1 bit_tick = 1'b0; line_high = 1'b1;
  endtask

  task automatic send_char(input logic [8:0] d, output logic acc);
    @(negedge clk); char_done = 1'b1; char_data = d;
    #1 acc = char_accept;
    @(posedge clk); #1 char_done = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    chk("R1 standby", standby, 1'b0);
    chk("R1 accept", char_accept, 1'b0);
    chk("R1 pin", pin_rx_en, 1'b0);
  endtask

  task automatic t_pin();
    @(negedge clk); rx_en = 1; loop_mode = 0; #1 chk("R10 on", pin_rx_en, 1'b1);
    @(negedge clk); loop_mode = 1; #1 chk("R10 loop", pin_rx_en, 1'b0);
    @(negedge clk); rx_en = 0; loop_mode = 0; #1 chk("R10 off", pin_rx_en, 1'b0);
  endtask

  task automatic t_normal();
    logic a;
    rx_en = 0; send_char(9'h041, a); chk("R9 disabled", a, 1'b0);
    rx_en = 1; send_char(9'h041, a); chk("R9 enabled", a, 1'b1);
  endtask

  task automatic t_request();
    rx_en = 0; req_standby(); chk("R2 ignored when off", standby, 1'b0);
    rx_en = 1; req_standby(); chk("R2 set", standby, 1'b1);
    rx_en = 0; @(posedge clk); #1;
    rx_en = 1;
  endtask

  task automatic t_mark8();
    logic a;
    wake_sel = 1; nine_bit = 0; req_standby();
    send_char(9'h05A, a); chk("R3 no mark", a, 1'b0); chk("R3 stays", standby, 1'b1);
    send_char(9'h0A5, a); chk("R4 accepted", a, 1'b1); chk("R4 woke", standby, 1'b0);
    send_char(9'h011, a); chk("R4 after", a, 1'b1);
  endtask

  task automatic t_mark9();
    logic a;
    wake_sel = 1; nine_bit = 1; req_standby();
    send_char(9'h080, a); chk("R5 bit7 only", a, 1'b0); chk("R5 stays", standby, 1'b1);
    send_char(9'h100, a); chk("R5 bit8", a, 1'b1); chk("R5 woke", standby, 1'b0);
    nine_bit = 0;
  endtask

  task automatic t_idle8();
    logic a;
    wake_sel = 0; nine_bit = 0; req_standby();
    send_char(9'h0FF, a); chk("R3 idle mode mute", a, 1'b0);
    for (int i = 0; i < 9; i++) send_tick(1'b1);
    chk("R6 nine ticks", standby, 1'b1);
    send_tick(1'b1); chk("R6 tenth tick", standby, 1'b0);
    send_char(9'h022, a); chk("R8 next char", a, 1'b1);
  endtask

  task automatic t_restart();
    wake_sel = 0; nine_bit = 0; req_standby();
    for (int i = 0; i < 5; i++) send_tick(1'b1);
    send_tick(1'b0);
    for (int i = 0; i < 9; i++) send_tick(1'b1);
    chk("R7 restarted", standby, 1'b1);
    send_tick(1'b1); chk("R7 full run", standby, 1'b0);
  endtask

  task automatic t_idle9();
    wake_sel = 0; nine_bit = 1; req_standby();
    for (int i = 0; i < 10; i++) send_tick(1'b1);
    chk("R6 9-bit ten ticks", standby, 1'b1);
    send_tick(1'b1); chk("R6 9-bit eleventh", standby, 1'b0);
    nine_bit = 0;
  endtask

  task automatic t_disable();
    wake_sel = 1; req_standby();
    @(negedge clk); rx_en = 0;
    @(posedge clk); #1 chk("R11 cleared", standby, 1'b0);
    @(negedge clk); rx_en = 1;
    @(posedge clk); #1 chk("R11 stays clear", standby, 1'b0);
  endtask

  task automatic t_collide();
    wake_sel = 1; req_standby();
    @(negedge clk); stby_req = 1; char_done = 1; char_data = 9'h080;
    #1 chk("R12 delivered", char_accept, 1'b1);
    @(posedge clk); #1 stby_req = 0; char_done = 0;
    chk("R12 stays", standby, 1'b1);
  endtask

  initial begin
    t_reset();
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    t_pin();
    t_normal();
    t_request();
    t_mark8();
    t_mark9();
    t_idle8();
    t_restart();
    t_idle9();
    t_disable();
    t_collide();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule